// File: doc/BRIEF.md
# Display List Transfer Engine

This block copies a run of 32-bit words from an external graphics memory into an internal display-list FIFO without the host moving any data. Software programs a word count and a base address, then writes 1 to a go bit. The engine fetches words one at a time through a request/response read port, starting at the base address. It pushes each word into the FIFO in address order and stops when the programmed number of words has been pushed. When the FIFO is full it holds back further reads, so the FIFO consumer sets the pace.

While a transfer is active, the FIFO belongs to the engine alone. Writes from the host or from a DMA channel are thrown away, and each such attempt sets a sticky violation flag. When the engine is idle, those two sources write the FIFO directly. The host wins if both write in the same cycle.

A state machine with four states runs the transfer:

- `ST_IDLE` waits for a start.
- `ST_ISSUE` presents a read request.
- `ST_WAIT` waits for the read data and pushes it.
- `ST_DONE` raises a one-cycle completion pulse.

The transitions are:

- **start**: IDLE to ISSUE, on a go write while idle.
- **fire**: ISSUE to WAIT, when the request is accepted while the FIFO is not full.
- **next**: WAIT to ISSUE, on response data when words remain.
- **last**: WAIT to DONE, on response data for the final word.
- **retire**: DONE to IDLE, always.

Top module: `dlist_xfer_engine`

## Requirements
- R1: After reset the engine is idle with no read request. The FIFO is empty, the done pulse is low, and all four registers read 0.
- R2: The count register at offset 0x0 holds CNT_W bits, and its upper bits read as 0. It keeps its value across transfers and changes only when software writes it.
- R3: A programmed count N of 1 or more transfers exactly N words. A count of 0 transfers 2^CNT_W words.
- R4: Reads start at the base register (offset 0x8) with its two low bits forced to 0. The address rises by 4 per word, and the words enter the FIFO in address order.
- R5: No read is requested while the FIFO is full, at most one read is outstanding, and the FIFO is never written while full.
- R6: Bit 0 of the go register (offset 0x4) starts a transfer when written as 1. It reads 1 while the transfer is active and 0 once the last word is pushed. Bits 31..1 read 0, and a write with bit 0 clear starts nothing.
- R7: Writing 1 to the go bit during an active transfer is ignored: the transfer keeps its original length and address sequence.
- R8: A host or DMA FIFO write during an active transfer is dropped and sets bit 0 of the status register (offset 0xC). That bit stays set until software writes 1 to it.
- R9: While the engine is idle, a host FIFO write pushes its data. A DMA FIFO write pushes only when the host is not writing in the same cycle. Neither one sets the violation bit.
- R10: The done output is high for exactly one cycle, in the cycle after the last word is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 4 | Register byte offset |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data (combinational) |
| host_fifo_wr | input | 1 | Host FIFO write strobe |
| host_fifo_data | input | DATA_W | Host FIFO write data |
| dma_fifo_wr | input | 1 | DMA FIFO write strobe |
| dma_fifo_data | input | DATA_W | DMA FIFO write data |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | ADDR_W | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DATA_W | Read data |
| fifo_rd | input | 1 | FIFO pop |
| fifo_rdata | output | DATA_W | FIFO head word (show-ahead) |
| fifo_empty | output | 1 | FIFO empty |
| fifo_full | output | 1 | FIFO full |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with CNT_W=4 and a FIFO DEPTH of 4. With these values a count of 0 means a 16-word transfer, so the maximum-length case finishes in a few dozen cycles instead of millions. A four-entry FIFO, drained on only every third cycle, fills up during most transfers and exercises the hold-off on reads. The bench also varies request acceptance so that the request handshake stalls at times.

// File: rtl/dlx_pkg.sv
package dlx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } xfer_state_e;

    localparam logic [1:0] REG_COUNT = 2'd0;
    localparam logic [1:0] REG_GO    = 2'd1;
    localparam logic [1:0] REG_BASE  = 2'd2;
    localparam logic [1:0] REG_STAT  = 2'd3;
endpackage

// File: rtl/dlx_regs.sv
module dlx_regs #(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [3:0]        host_addr,
    input  logic [31:0]       host_wdata,
    input  logic              busy,
    input  logic              idle,
    input  logic              viol_event,
    output logic [31:0]       host_rdata,
    output logic [CNT_W-1:0]  count_q,
    output logic [ADDR_W-1:0] base_q,
    output logic              start_pulse
);
    import dlx_pkg::*;

    logic [1:0] sel;
    logic       viol_q;
    logic       viol_clr;

    assign sel         = host_addr[3:2];
    assign start_pulse = host_wr && (sel == REG_GO) && host_wdata[0] && idle;
    assign viol_clr    = host_wr && (sel == REG_STAT) && host_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            base_q  <= '0;
        end else if (host_wr) begin
            if (sel == REG_COUNT) count_q <= host_wdata[CNT_W-1:0];
            if (sel == REG_BASE)  base_q  <= {host_wdata[ADDR_W-1:2], 2'b00};
        end
    end

    // Sticky flag: a new violation wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)          viol_q <= 1'b0;
        else if (viol_event) viol_q <= 1'b1;
        else if (viol_clr)   viol_q <= 1'b0;
    end

    always_comb begin
        host_rdata = '0;
        unique case (sel)
            REG_COUNT: host_rdata = {{(32-CNT_W){1'b0}}, count_q};
            REG_GO:    host_rdata = {31'b0, busy};
            REG_BASE:  host_rdata = 32'(base_q);
            REG_STAT:  host_rdata = {31'b0, viol_q};
        endcase
    end

    assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_q && !viol_clr) |=> viol_q);
    assert_sticky_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol_q) |-> $past(viol_event));
endmodule

// File: rtl/dlx_fifo.sv
module dlx_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     fill;
    logic              do_push, do_pop;

    assign empty   = (fill == '0);
    assign full    = (fill == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            fill <= fill + CW'(do_push) - CW'(do_pop);
        end
    end

    assert_no_push_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
endmodule

// File: rtl/dlx_fsm.sv
module dlx_fsm #(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pulse,
    input  logic [CNT_W-1:0]  count_q,
    input  logic [ADDR_W-1:0] base_q,
    input  logic              fifo_full,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              busy,
    output logic              idle,
    output logic              done
);
    import dlx_pkg::*;

    localparam int LEN_W = CNT_W + 1;
    localparam logic [LEN_W-1:0] MAX_LEN = {1'b1, {CNT_W{1'b0}}};

    xfer_state_e       state_q, state_d;
    logic [LEN_W-1:0]  left_q;
    logic [ADDR_W-1:0] addr_q;
    logic              fire;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_pulse) state_d = ST_ISSUE;
            ST_ISSUE: if (fire)        state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid)
                          state_d = (left_q == LEN_W'(1)) ? ST_DONE : ST_ISSUE;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req_valid = 1'b0;
        push          = 1'b0;
        busy          = 1'b0;
        idle          = 1'b0;
        done          = 1'b0;
        unique case (state_q)
            ST_IDLE:  idle = 1'b1;
            ST_ISSUE: begin
                busy          = 1'b1;
                mem_req_valid = !fifo_full;
            end
            ST_WAIT: begin
                busy = 1'b1;
                push = mem_rsp_valid;
            end
            ST_DONE:  done = 1'b1;
        endcase
    end

    assign fire         = mem_req_valid && mem_req_ready;
    assign mem_req_addr = addr_q;
    assign push_data    = mem_rsp_data;

    // Address and remaining-word counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start_pulse) begin
                addr_q <= base_q;
                left_q <= (count_q == '0) ? MAX_LEN : LEN_W'(count_q);
            end else begin
                if (fire) addr_q <= addr_q + ADDR_W'(4);
                if (push) left_q <= left_q - LEN_W'(1);
            end
        end
    end

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_len_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (left_q != '0));
    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (mem_req_addr == $past(mem_req_addr) + ADDR_W'(4)));
    assert_start_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (state_q == ST_IDLE));
    assert_one_outstanding_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> !mem_req_valid);
endmodule

// File: rtl/dlist_xfer_engine.sv
module dlist_xfer_engine #(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [3:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic              host_fifo_wr,
    input  logic [DATA_W-1:0] host_fifo_data,
    input  logic              dma_fifo_wr,
    input  logic [DATA_W-1:0] dma_fifo_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              fifo_rd,
    output logic [DATA_W-1:0] fifo_rdata,
    output logic              fifo_empty,
    output logic              fifo_full
    ,output logic             xfer_done
);
    logic [CNT_W-1:0]  count_q;
    logic [ADDR_W-1:0] base_q;
    logic              start_pulse, busy, idle, viol_event;
    logic              eng_push, ext_push, fifo_push;
    logic [DATA_W-1:0] eng_data, ext_data, fifo_wdata;

    assign viol_event = busy && (host_fifo_wr || dma_fifo_wr);
    assign ext_push   = !busy && (host_fifo_wr || dma_fifo_wr) && !fifo_full;
    assign ext_data   = host_fifo_wr ? host_fifo_data : dma_fifo_data;
    assign fifo_push  = eng_push || ext_push;
    assign fifo_wdata = eng_push ? eng_data : ext_data;

    dlx_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk, .rst_n, .host_wr, .host_addr, .host_wdata,
        .busy, .idle, .viol_event, .host_rdata,
        .count_q, .base_q, .start_pulse
    );

    dlx_fsm #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk, .rst_n, .start_pulse, .count_q, .base_q,
        .fifo_full, .mem_req_ready, .mem_rsp_valid, .mem_rsp_data,
        .mem_req_valid, .mem_req_addr,
        .push(eng_push), .push_data(eng_data),
        .busy, .idle, .done(xfer_done)
    );

    dlx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk, .rst_n, .push(fifo_push), .push_data(fifo_wdata),
        .pop(fifo_rd), .head(fifo_rdata), .empty(fifo_empty), .full(fifo_full)
    );

    assert_lockout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_fifo_wr && busy) |=> !$past(fifo_push && !eng_push));
endmodule

// File: tb/dlist_xfer_engine_test.sv
module dlist_xfer_engine_test;
    localparam int CNT_W = 4;
    localparam int DEPTH = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        host_wr = 0;
    logic [3:0]  host_addr = 0;
    logic [31:0] host_wdata = 0;
    logic [31:0] host_rdata;
    logic        host_fifo_wr = 0, dma_fifo_wr = 0;
    logic [31:0] host_fifo_data = 0, dma_fifo_data = 0;
    logic        mem_req_valid, mem_req_ready = 1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 0;
    logic [31:0] mem_rsp_data = 0;
    logic        fifo_rd = 0;
    logic [31:0] fifo_rdata;
    logic        fifo_empty, fifo_full, xfer_done;

    int total = 0, bad = 0, cyc = 0, r5_err = 0, pend = 0;

    always #2 clk = ~clk;

    dlist_xfer_engine #(.CNT_W(CNT_W), .ADDR_W(32), .DATA_W(32), .DEPTH(DEPTH)) uut (
        .clk, .rst_n, .host_wr, .host_addr, .host_wdata, .host_rdata,
        .host_fifo_wr, .host_fifo_data, .dma_fifo_wr, .dma_fifo_data,
        .mem_req_valid, .mem_req_ready, .mem_req_addr,
        .mem_rsp_valid, .mem_rsp_data,
        .fifo_rd, .fifo_rdata, .fifo_empty, .fifo_full, .xfer_done
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    // Memory model: one-cycle read latency, request acceptance stalls now and then
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rsp_valid <= mem_req_valid && mem_req_ready;
        mem_rsp_data  <= mem_word(mem_req_addr);
        mem_req_ready <= (cyc % 5) != 2;
    end

    // R5 monitor: no request while full, no second request before a response
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req_valid && fifo_full) r5_err++;
            if (mem_req_valid && mem_req_ready) begin
                if (pend != 0) r5_err++;
                pend = 1;
            end else if (mem_rsp_valid) pend = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    // Start a transfer; optionally disturb it; drain and check every word
    task automatic run_xfer(input logic [CNT_W-1:0] cnt, input logic [31:0] base,
                            input bit disturb);
        logic [31:0] rd, abase;
        int n, k, dones, t;
        n = (cnt == 0) ? (1 << CNT_W) : int'(cnt);
        abase = {base[31:2], 2'b00};
        k = 0; dones = 0;
        reg_write(4'h0, 32'(cnt));
        reg_write(4'h8, base);
        reg_write(4'h4, 32'h1);
        reg_read(4'h4, rd);
        chk(rd == 32'h1, "R6", "go reads 1 while active", rd, 32'h1);
        for (t = 0; t < 600; t++) begin
            @(negedge clk);
            fifo_rd = 0; host_fifo_wr = 0; dma_fifo_wr = 0; host_wr = 0;
            if (disturb && t == 3) begin
                host_wr = 1; host_addr = 4'h4; host_wdata = 32'h1;   // R7 restart attempt
                host_fifo_wr = 1; host_fifo_data = 32'hDEAD_0001;    // R8 host intrusion
            end
            if (disturb && t == 5) begin
                dma_fifo_wr = 1; dma_fifo_data = 32'hDEAD_0002;      // R8 DMA intrusion
            end
            if (xfer_done) dones++;
            if (!fifo_empty && (cyc % 3 == 0) && k < n) begin
                chk(fifo_rdata == mem_word(abase + 32'(4 * k)), "R4",
                    "word order/address", fifo_rdata, mem_word(abase + 32'(4 * k)));
                k++;
                fifo_rd = 1;
            end
            if (k == n && dones > 0 && fifo_empty) break;
        end
        @(negedge clk);
        fifo_rd = 0; host_fifo_wr = 0; dma_fifo_wr = 0; host_wr = 0;
        chk(k == n, "R3", "word count", 32'(k), 32'(n));
        chk(dones == 1, "R10", "done pulses", 32'(dones), 32'h1);
        chk(fifo_empty, "R3", "no extra words", 32'(fifo_empty), 32'h1);
        reg_read(4'h4, rd);
        chk(rd == 32'h0, "R6", "go clears after last push", rd, 32'h0);
        reg_read(4'h0, rd);
        chk(rd == 32'(cnt), "R2", "count persists", rd, 32'(cnt));
    endtask

    // count in [35:32], base in [31:0]
    localparam logic [35:0] VEC [0:5] = '{
        {4'd1,  32'h0000_0100},
        {4'd3,  32'h0000_2003},
        {4'd5,  32'h0000_0040},
        {4'd0,  32'h0000_0800},
        {4'd15, 32'h0000_FFC0},
        {4'd4,  32'h0000_7FFC}
    };

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            reg_read(4'(a * 4), rd);
            chk(rd == 32'h0, "R1", "register after reset", rd, 32'h0);
        end
        chk(fifo_empty && !mem_req_valid && !xfer_done, "R1", "idle outputs",
            {29'b0, fifo_empty, mem_req_valid, xfer_done}, 32'h4);

        // R2 reserved count bits, R6 reserved go bits / bit0 clear starts nothing
        reg_write(4'h0, 32'hFFFF_FFF7);
        reg_read(4'h0, rd);
        chk(rd == 32'h7, "R2", "count upper bits zero", rd, 32'h7);
        reg_write(4'h4, 32'hFFFF_FFFE);
        @(negedge clk);
        reg_read(4'h4, rd);
        chk(rd == 32'h0 && !mem_req_valid, "R6", "bit0 clear no start", rd, 32'h0);

        // Table-driven transfers (R3, R4, R5, R10)
        for (int i = 0; i < 6; i++)
            run_xfer(VEC[i][35:32], VEC[i][31:0], 1'b0);

        // R7 / R8 during an active transfer
        run_xfer(4'd6, 32'h0000_3000, 1'b1);
        reg_read(4'hC, rd);
        chk(rd == 32'h1, "R8", "violation sticky set", rd, 32'h1);
        reg_write(4'hC, 32'h0);
        reg_read(4'hC, rd);
        chk(rd == 32'h1, "R8", "write 0 keeps flag", rd, 32'h1);
        reg_write(4'hC, 32'h1);
        reg_read(4'hC, rd);
        chk(rd == 32'h0, "R8", "write 1 clears flag", rd, 32'h0);

        // R9 idle writes: host beats DMA in the same cycle
        @(negedge clk);
        host_fifo_wr = 1; host_fifo_data = 32'hAAAA_0001;
        dma_fifo_wr = 1;  dma_fifo_data  = 32'hBBBB_0002;
        @(negedge clk);
        host_fifo_wr = 0;
        dma_fifo_data = 32'hCCCC_0003;
        @(negedge clk);
        dma_fifo_wr = 0;
        chk(fifo_rdata == 32'hAAAA_0001, "R9", "host wins", fifo_rdata, 32'hAAAA_0001);
        fifo_rd = 1;
        @(negedge clk);
        fifo_rd = 0;
        chk(fifo_rdata == 32'hCCCC_0003, "R9", "dma alone pushes", fifo_rdata, 32'hCCCC_0003);
        fifo_rd = 1;
        @(negedge clk);
        fifo_rd = 0;
        chk(fifo_empty, "R9", "dma dropped under host", 32'(fifo_empty), 32'h1);
        reg_read(4'hC, rd);
        chk(rd == 32'h0, "R9", "idle writes no violation", rd, 32'h0);

        chk(r5_err == 0, "R5", "request while full/outstanding", 32'(r5_err), 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule